// File: doc/BRIEF.md
# TDM Time-Slot Bit Router

This block sits between a serial time-division-multiplexed line and a small set of channel ports. A frame sync marks the start of each frame. From then on, a sequencer reads a short table of route entries. Each entry covers a run of bits, or a run of whole bytes, and gives that run to one channel port or to no port at all. Receive and transmit each have their own table and their own sequencer, so the two directions can split the frame differently.

On the receive side, the line is sampled on the falling edge of the bit clock. Each accepted bit appears on a shared data output, together with a one-cycle strobe for the channel that owns the slot. On the transmit side, at each rising edge of the bit clock the block takes the next bit from the owning channel and drives it. It signals that the line is undriven, through a low output enable, for any slot that no channel owns. A grant input is sampled with the receive frame sync and passed on for the D-channel port. A frame sync that arrives before the current frame has finished sets a sticky error flag.

The bit clocks and syncs are treated as slow inputs sampled by the fast system clock. The tables are written through a small register port. They can be written only while the interface is disabled.

Top module: `tdm_slot_router`

## Requirements
- R1: A route entry is 9 bits: [3:0] channel select, [6:4] count, [7] unit (0 = bits, 1 = bytes), [8] last. A write with `cfg_wr` high stores `cfg_wdata` at `cfg_addr` in the receive table when `cfg_tx_sel` is 0, or in the transmit table when it is 1. It takes effect only while `cfg_en` is low. A write while `cfg_en` is high leaves the table unchanged.
- R2: An entry covers count+1 bit slots when its unit is 0, and 8*(count+1) bit slots when its unit is 1. Consecutive entries cover consecutive slots.
- R3: A channel select of 0, or of any value above `NUM_CH`, owns no channel. On receive its bits raise no strobe. On transmit `tx_oe` is low for its slots and no `ch_tx_take` bit pulses.
- R4: Frame sync is sampled on the falling edge of the bit clock. The slot sampled at that edge carries no data. The first slot of entry 0 is the one sampled at the next falling edge.
- R5: At a falling edge of `rx_bclk`, for a slot owned by channel c (select c+1), `ch_rx_stb[c]` is high for exactly one system clock and `rx_bit` holds the sampled `rx_data`. Both appear one system clock after the edge is seen. At most one strobe is high at a time.
- R6: At each rising edge of the transmit bit clock, for the next slot, owned by channel c: `tx_oe` goes high, `tx_data` takes `ch_tx_bits[c]`, and `ch_tx_take[c]` pulses for one system clock. These values hold until the next rising edge.
- R7: When the entry with the last flag set, or entry 15, has used up its run, the sequencer goes idle. It then gives no strobe and keeps `tx_oe` low until the next frame sync, which restarts it at entry 0.
- R8: A frame sync seen by either direction while its sequencer is still active restarts that sequencer at entry 0 and sets `sync_err`. `sync_err` stays high until `cfg_en` is low.
- R9: With `cfg_shared_timing` high, the transmit sequencer uses `rx_bclk` and `rx_fsync` and ignores `tx_bclk` and `tx_fsync`. With it low, it uses its own pair.
- R10: `grant_in` is sampled at each falling `rx_bclk` edge where `rx_fsync` is high. The sampled value is held on `dch_grant` until the next such edge.
- R11: While `cfg_en` is low, both sequencers are idle, no strobe or take pulses, `tx_oe` is low and `sync_err` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Interface enable; tables writable only when low |
| cfg_shared_timing | input | 1 | Transmit side uses the receive bit clock and sync |
| cfg_wr | input | 1 | Table write strobe |
| cfg_tx_sel | input | 1 | Write target: 0 receive table, 1 transmit table |
| cfg_addr | input | IDX_W (4) | Table entry index |
| cfg_wdata | input | 9 | Route entry value |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_data | input | 1 | Receive serial line |
| tx_bclk | input | 1 | Transmit bit clock (unshared mode) |
| tx_fsync | input | 1 | Transmit frame sync (unshared mode) |
| ch_tx_bits | input | NUM_CH (4) | Next transmit bit offered by each channel |
| grant_in | input | 1 | Line access grant |
| rx_bit | output | 1 | Last accepted receive bit |
| ch_rx_stb | output | NUM_CH (4) | Per-channel receive strobe |
| tx_data | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Transmit drive enable (low = line released) |
| ch_tx_take | output | NUM_CH (4) | Per-channel pulse: transmit bit consumed |
| dch_grant | output | 1 | Grant sampled at the last receive frame sync |
| sync_err | output | 1 | Sticky early-sync flag |

## Verification
A wrong entry index or run counter moves the boundary between two channels. The fault shows on the first slot past the bad boundary: the strobe lands on the wrong channel bit, or `tx_oe` rises or falls one bit clock early or late. Faults in idle detection show within one bit clock after the frame should have ended, as a stray strobe or an output enable left high. A lost restart on early sync shows on the very next data slot, as wrong ownership together with a missing `sync_err`. The bench sweeps every count and unit value and checks each slot of every frame. Even an off-by-one in a run length is therefore visible within the frame that contains it.

// File: rtl/tsr_pkg.sv
// Shared definitions for the TDM slot router.
// Assumes entries are packed as {last, unit, count, select}.
package tsr_pkg;

    localparam int CSEL_W = 4;
    localparam int CNT_W  = 3;
    localparam int ENT_W  = CSEL_W + CNT_W + 2;
    // enough for 8 bytes of 8 bits
    localparam int RUN_W  = CNT_W + 4;

    typedef struct packed {
        logic              last;
        logic              unit;
        logic [CNT_W-1:0]  cnt;
        logic [CSEL_W-1:0] csel;
    } route_ent_t;

    // Number of bit slots covered by an entry.
    function automatic logic [RUN_W-1:0] run_len(input route_ent_t e);
        logic [RUN_W-1:0] n;
        n = RUN_W'(e.cnt) + RUN_W'(1);
        return e.unit ? (n << 3) : n;
    endfunction

endpackage

// File: rtl/tsr_edge_det.sv
// Edge detector for a slow line clock sampled by the system clock.
// Assumes the input is already synchronous and changes slower than clk.
module tsr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev_q;

    // Remember the previous level of the line clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/tsr_route_table.sv
// Route table: DEPTH entries, one write port, two combinational read ports.
// Assumes writes are only accepted while the interface is locked off.
module tsr_route_table
    import tsr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  route_ent_t       wr_data,
    input  logic [IDX_W-1:0] rd_a_addr,
    output route_ent_t       rd_a,
    input  logic [IDX_W-1:0] rd_b_addr,
    output route_ent_t       rd_b
);

    localparam int MEM_W = DEPTH * ENT_W;

    logic [MEM_W-1:0] mem_q;

    // Store an entry when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_q <= '0;
        else if (wr_en && !lock)
            mem_q[wr_addr*ENT_W +: ENT_W] <= wr_data;
    end

    assign rd_a = route_ent_t'(mem_q[rd_a_addr*ENT_W +: ENT_W]);
    assign rd_b = route_ent_t'(mem_q[rd_b_addr*ENT_W +: ENT_W]);

    AST_TABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(mem_q)); // R1

endmodule

// File: rtl/tsr_seq.sv
// Frame sequencer: walks the route table one bit slot per falling edge.
// Assumes ent_cur is the entry at idx_o and ent_nxt the entry at nxt_addr_o.
module tsr_seq
    import tsr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fall,
    input  logic             sync,
    input  route_ent_t       ent_cur,
    input  route_ent_t       ent_nxt,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] nxt_addr_o,
    output logic             active_o,
    output logic             err_o
);

    logic [RUN_W-1:0] left_q;
    logic [IDX_W-1:0] idx_q;
    logic             active_q;
    logic             is_last;

    assign is_last    = ent_cur.last || (idx_q == IDX_W'(DEPTH - 1));
    assign nxt_addr_o = sync ? '0 : idx_q + 1'b1;
    assign err_o      = en && fall && sync && active_q;
    assign idx_o      = idx_q;
    assign active_o   = active_q;

    // Advance through runs and entries on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            left_q   <= '0;
        end else if (fall) begin
            if (sync) begin
                active_q <= 1'b1;
                idx_q    <= '0;
                left_q   <= run_len(ent_nxt) - 1'b1;
            end else if (active_q) begin
                if (left_q == '0) begin
                    if (is_last) begin
                        active_q <= 1'b0;
                    end else begin
                        idx_q  <= idx_q + 1'b1;
                        left_q <= run_len(ent_nxt) - 1'b1;
                    end
                end else begin
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active_q); // R11
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fall && sync) |=> (active_q && idx_q == '0)); // R8
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fall && !sync && active_q && left_q == '0 && is_last) |=> !active_q); // R7

endmodule

// File: rtl/tdm_slot_router.sv
// TDM time-slot bit router: routes bit slots of a serial frame to channel
// ports through separate receive and transmit run-length route tables.
// Assumes bit clocks and syncs are synchronous to clk and much slower.
module tdm_slot_router
    import tsr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_shared_timing,
    input  logic              cfg_wr,
    input  logic              cfg_tx_sel,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [ENT_W-1:0]  cfg_wdata,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_data,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    input  logic [NUM_CH-1:0] ch_tx_bits,
    input  logic              grant_in,
    output logic              rx_bit,
    output logic [NUM_CH-1:0] ch_rx_stb,
    output logic              tx_data,
    output logic              tx_oe,
    output logic [NUM_CH-1:0] ch_tx_take,
    output logic              dch_grant,
    output logic              sync_err
);

    localparam int NSIDE = 2;   // 0 = receive, 1 = transmit

    logic [NSIDE-1:0] bclk_s, fs_s, rise_s, fall_s, active_s, err_s;
    route_ent_t       cur_s [NSIDE];
    route_ent_t       nxt_s [NSIDE];
    logic [IDX_W-1:0] idx_s [NSIDE];
    logic [IDX_W-1:0] nadr_s[NSIDE];
    logic [NUM_CH-1:0] rx_sel, tx_sel;

    // Timing source selection per direction.
    assign bclk_s[0] = rx_bclk;
    assign fs_s[0]   = rx_fsync;
    assign bclk_s[1] = cfg_shared_timing ? rx_bclk  : tx_bclk;
    assign fs_s[1]   = cfg_shared_timing ? rx_fsync : tx_fsync;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        tsr_edge_det u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (bclk_s[s]),
            .rise (rise_s[s]),
            .fall (fall_s[s])
        );

        tsr_route_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tab (
            .clk      (clk),
            .rst_n    (rst_n),
            .lock     (cfg_en),
            .wr_en    (cfg_wr && (cfg_tx_sel == 1'(s))),
            .wr_addr  (cfg_addr),
            .wr_data  (route_ent_t'(cfg_wdata)),
            .rd_a_addr(idx_s[s]),
            .rd_a     (cur_s[s]),
            .rd_b_addr(nadr_s[s]),
            .rd_b     (nxt_s[s])
        );

        tsr_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (cfg_en),
            .fall      (fall_s[s]),
            .sync      (fs_s[s]),
            .ent_cur   (cur_s[s]),
            .ent_nxt   (nxt_s[s]),
            .idx_o     (idx_s[s]),
            .nxt_addr_o(nadr_s[s]),
            .active_o  (active_s[s]),
            .err_o     (err_s[s])
        );
    end

    // Channel ownership of the current slot, one bit per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign rx_sel[c] = active_s[0] && (cur_s[0].csel == CSEL_W'(c + 1));
        assign tx_sel[c] = active_s[1] && (cur_s[1].csel == CSEL_W'(c + 1));
    end

    // Receive: capture the line bit and strobe its owner on a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) begin
            ch_rx_stb <= '0;
            rx_bit    <= 1'b0;
        end else if (fall_s[0] && !fs_s[0] && (|rx_sel)) begin
            ch_rx_stb <= rx_sel;
            rx_bit    <= rx_data;
        end else begin
            ch_rx_stb <= '0;
        end
    end

    // Transmit: launch the owner's bit, or release the line, on a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) begin
            tx_oe      <= 1'b0;
            tx_data    <= 1'b0;
            ch_tx_take <= '0;
        end else if (rise_s[1]) begin
            tx_oe      <= |tx_sel;
            tx_data    <= |(tx_sel & ch_tx_bits);
            ch_tx_take <= tx_sel;
        end else begin
            ch_tx_take <= '0;
        end
    end

    // Grant capture at the receive frame sync.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dch_grant <= 1'b0;
        else if (cfg_en && fall_s[0] && fs_s[0])
            dch_grant <= grant_in;
    end

    // Sticky early-sync flag, cleared by disabling the interface.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en)
            sync_err <= 1'b0;
        else if (|err_s)
            sync_err <= 1'b1;
    end

    AST_RX_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rx_stb)); // R5
    AST_RX_STB_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_rx_stb) |-> $past(fall_s[0])); // R5
    AST_TX_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_tx_take)); // R6
    AST_TAKE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_tx_take) |-> tx_oe); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && sync_err) |=> sync_err); // R8
    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!tx_oe && ch_rx_stb == '0 && !sync_err)); // R11

endmodule

// File: tb/tdm_slot_router_bench.sv
module tdm_slot_router_bench;

    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_shared = 1'b1, cfg_wr = 1'b0, cfg_tx_sel = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [8:0] cfg_wdata = '0;
    logic       rx_bclk = 1'b0, rx_fsync = 1'b0, rx_data = 1'b0;
    logic       tx_bclk = 1'b0, tx_fsync = 1'b0;
    logic [3:0] ch_tx_bits = '0;
    logic       grant_in = 1'b0;
    logic       rx_bit, tx_data, tx_oe, dch_grant, sync_err;
    logic [3:0] ch_rx_stb, ch_tx_take;

    int vectors = 0, miscompares = 0;
    logic [8:0] mdl [2][16];
    logic [3:0] cap_stb, cap_take;
    logic       cap_rxbit, cap_oe, cap_txd;

    always #2.5 clk = ~clk;

    tdm_slot_router u_tdm_slot_router (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_shared_timing(cfg_shared),
        .cfg_wr(cfg_wr), .cfg_tx_sel(cfg_tx_sel), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_bclk(rx_bclk), .rx_fsync(rx_fsync),
        .rx_data(rx_data), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
        .ch_tx_bits(ch_tx_bits), .grant_in(grant_in), .rx_bit(rx_bit),
        .ch_rx_stb(ch_rx_stb), .tx_data(tx_data), .tx_oe(tx_oe),
        .ch_tx_take(ch_tx_take), .dch_grant(dch_grant), .sync_err(sync_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Owner (1..NCH) of slot pos in a table, 0 for none or past frame end.
    function automatic int owner(input int side, input int pos);
        int acc = 0;
        for (int e = 0; e < 16; e++) begin
            int len = (int'(mdl[side][e][6:4]) + 1) * (mdl[side][e][7] ? 8 : 1);
            int cs  = int'(mdl[side][e][3:0]);
            if (pos < acc + len) return (cs >= 1 && cs <= NCH) ? cs : 0;
            acc += len;
            if (mdl[side][e][8]) break;
        end
        return 0;
    endfunction

    task automatic wr_ent(input int side, input int addr, input logic [8:0] v, input bit upd);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_tx_sel = 1'(side); cfg_addr = 4'(addr); cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (upd) mdl[side][addr] = v;
    endtask

    // One bit clock: rising edge (transmit launch), then falling (receive sample).
    task automatic do_bit(input logic fsr, input logic fst, input logic d, input logic [3:0] txp);
        @(negedge clk);
        rx_bclk = 1'b1; tx_bclk = 1'b1; ch_tx_bits = txp;
        @(negedge clk);
        cap_oe = tx_oe; cap_txd = tx_data; cap_take = ch_tx_take;
        @(negedge clk);
        rx_fsync = fsr; tx_fsync = fst; rx_data = d;
        rx_bclk = 1'b0; tx_bclk = 1'b0;
        @(negedge clk);
        cap_stb = ch_rx_stb; cap_rxbit = rx_bit;
    endtask

    // Sync then nbits data slots, every slot checked against the model.
    task automatic run_frame(input int nbits, input bit tx_live, input logic tx_pin_fs,
                             input int seed, input string tag);
        do_bit(1'b1, tx_pin_fs, 1'b0, 4'h0);
        check({tag, " R4 sync slot carries no strobe"}, 32'(cap_stb), 0);
        for (int b = 0; b < nbits; b++) begin
            logic d;
            logic [3:0] txp;
            int ro, to;
            d   = 1'(((b * 5) ^ (b >> 1) ^ seed) & 1);
            txp = 4'(b * 7 + seed * 3);
            do_bit(1'b0, 1'b0, d, txp);
            ro = owner(0, b);
            to = tx_live ? owner(1, b) : 0;
            check({tag, (ro == 0) ? " R3 rx no owner" : " R5 rx strobe"},
                  32'(cap_stb), (ro == 0) ? 0 : (1 << (ro - 1)));
            if (ro != 0) check({tag, " R5 rx bit"}, 32'(cap_rxbit), 32'(d));
            check({tag, (to == 0) ? " R3 tx released" : " R6 tx oe"}, 32'(cap_oe), (to != 0) ? 1 : 0);
            check({tag, " R6 tx take"}, 32'(cap_take), (to == 0) ? 0 : (1 << (to - 1)));
            if (to != 0) check({tag, " R6 tx data"}, 32'(cap_txd), 32'(txp[to-1]));
        end
    endtask

    function automatic int frame_len(input int side);
        int acc = 0;
        for (int e = 0; e < 16; e++) begin
            acc += (int'(mdl[side][e][6:4]) + 1) * (mdl[side][e][7] ? 8 : 1);
            if (mdl[side][e][8]) break;
        end
        return acc;
    endfunction

    task automatic set_en(input logic v);
        @(negedge clk); cfg_en = v; @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int s = 0; s < 2; s++) for (int e = 0; e < 16; e++) mdl[s][e] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset oe", 32'(tx_oe), 0);
        check("R11 reset strobes", 32'({ch_rx_stb, ch_tx_take}), 0);
        check("R8 reset sync_err", 32'(sync_err), 0);
        check("R10 reset grant", 32'(dch_grant), 0);

        // Mixed table: byte to ch1, bit to ch0, bit unrouted, 4 bits to ch3.
        wr_ent(0, 0, 9'b0_1_000_0010, 1);
        wr_ent(0, 1, 9'b0_0_000_0001, 1);
        wr_ent(0, 2, 9'b0_0_000_0000, 1);
        wr_ent(0, 3, 9'b1_0_011_0100, 1);
        // Transmit table differs: 3 bits ch2, 2 bits select 9 (none), byte ch0.
        wr_ent(1, 0, 9'b0_0_010_0011, 1);
        wr_ent(1, 1, 9'b0_0_001_1001, 1);
        wr_ent(1, 2, 9'b1_1_000_0001, 1);
        set_en(1'b1);
        grant_in = 1'b1;
        run_frame(18, 1, 1'b0, 1, "R2 mixed");
        check("R10 grant captured high", 32'(dch_grant), 1);
        grant_in = 1'b0;
        run_frame(18, 1, 1'b0, 2, "R7 repeat");
        check("R10 grant captured low", 32'(dch_grant), 0);
        check("R8 no early sync", 32'(sync_err), 0);

        // Early sync: restart at entry 0 and sticky error.
        run_frame(5, 1, 1'b0, 3, "R8 partial");
        grant_in = 1'b1;
        run_frame(18, 1, 1'b0, 4, "R8 restart");
        check("R8 sync_err set", 32'(sync_err), 1);
        run_frame(18, 1, 1'b0, 5, "R8 after");
        check("R8 sync_err sticky", 32'(sync_err), 1);

        // Write while enabled is ignored.
        wr_ent(0, 0, 9'b1_0_000_0000, 0);
        wr_ent(1, 0, 9'b1_0_000_0000, 0);
        run_frame(18, 1, 1'b0, 6, "R1 locked");

        // Disable clears everything and stops routing.
        set_en(1'b0);
        check("R11 sync_err cleared", 32'(sync_err), 0);
        do_bit(1'b1, 1'b0, 1'b1, 4'hF);
        do_bit(1'b0, 1'b0, 1'b1, 4'hF);
        check("R11 no strobe disabled", 32'(cap_stb), 0);
        check("R11 no oe disabled", 32'({cap_oe, cap_take}), 0);

        // Sweep every count and unit value.
        for (int u = 0; u < 2; u++) begin
            for (int c = 0; c < 8; c++) begin
                logic [8:0] e0;
                e0 = {1'b0, 1'(u), 3'(c), 4'(1 + (c % NCH))};
                set_en(1'b0);
                wr_ent(0, 0, e0, 1);
                wr_ent(0, 1, 9'b1_0_000_0010, 1);
                wr_ent(1, 0, e0, 1);
                wr_ent(1, 1, 9'b1_0_000_0011, 1);
                set_en(1'b1);
                run_frame(frame_len(0) + 2, 1, 1'b0, u * 8 + c, "R2 sweep");
            end
        end

        // No last flag anywhere: frame ends after entry 15.
        set_en(1'b0);
        for (int e = 0; e < 16; e++) begin
            wr_ent(0, e, {1'b0, 1'b0, 3'(e % 2), 4'(e % 6)}, 1);
            wr_ent(1, e, {1'b0, 1'b0, 3'(e % 2), 4'((e + 2) % 6)}, 1);
        end
        set_en(1'b1);
        run_frame(frame_len(0) + 3, 1, 1'b0, 9, "R7 table end");

        // Separate transmit timing: no transmit sync means no transmit frame.
        set_en(1'b0);
        cfg_shared = 1'b0;
        set_en(1'b1);
        run_frame(frame_len(0) + 1, 0, 1'b0, 10, "R9 own sync idle");
        run_frame(frame_len(0) + 1, 1, 1'b1, 11, "R9 own sync live");
        check("R8 clean frames", 32'(sync_err), 0);

        finish_run();
    end

endmodule